// File: doc/BRIEF.md
# Interrupt-Capable GPIO Controller

This block is a 32-pin general-purpose I/O controller with a plain 32-bit register bus. Software sets, per pin, whether the pin drives, what level it drives, an inversion of that level, a pull level used when nothing drives the pin, and whether the pin is sampled. The block resolves the level present on each pin every clock and stores the sampled level. From that stored sample it keeps four sticky pending flags per pin: level high, level low, rising change and falling change.

The pin side is modelled as an external drive-enable and drive-value per pin, coming from outside the chip, plus a resolved level per pin going out. Each pin has its own interrupt line. The line is raised when any pending flag of that pin is set while the matching enable is set. Drive-strength and alternate-function settings are held as plain storage and change no pin behaviour. A per-pin conflict flag marks pins that are driven from outside while their own output is enabled. The flag exists for bench checking.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register reads 0, and pin_out, irq_out and conflict are all 0.
- R2: Aligned 32-bit registers at these byte offsets read back what was last written: 0x04 sample enable, 0x08 output enable, 0x0C output level, 0x10 pull level, 0x14 drive strength, 0x18 rise enable, 0x20 fall enable, 0x28 high enable, 0x30 low enable, 0x38 alternate-function enable, 0x3C alternate-function select, 0x40 output invert. Offset 0x00 returns the stored sample, and writes to it are ignored.
- R3: A pin that is not driven from outside, with its output enable set, carries (output level XOR output invert).
- R4: The level on a pin is chosen in priority order: the external value when external drive is enabled, then the internal output when output enable is set, and otherwise the pull bit.
- R5: Each clock stores (sample enable AND pin level) per pin. The result is readable at 0x00 from the cycle after the pin changes.
- R6: The high pending bit (0x2C) sets whenever the stored sample is 1, and the low pending bit (0x34) sets whenever it is 0. Both stay set until they are cleared.
- R7: The rise pending bit (0x1C) sets when the new sample is 1 and the previously stored one was 0. The fall pending bit (0x24) sets on the opposite change. Both are sticky.
- R8: Writing 1 to a bit of any pending register clears that bit, and writing 0 leaves it unchanged. When a set condition and a clear happen in the same cycle, the bit ends up set.
- R9: irq_out[i] is the OR of the four products (pending AND enable) of pin i.
- R10: Reads of undefined offsets (0x44 and above) and of unaligned addresses (low two bits not 00) return 0. Writes to such addresses change nothing.
- R11: conflict[i] is 1 exactly when pin i is driven from outside while its output enable is set. In that case the pin carries the external value.
- R12: The drive-strength and alternate-function registers have no effect on pin_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ext_drive_en | input | 32 | Per pin: driven from outside |
| ext_drive_val | input | 32 | Per pin: external level |
| pin_out | output | 32 | Resolved pin levels |
| irq_out | output | 32 | Per-pin interrupt lines |
| conflict | output | 32 | Per pin: external drive while output enabled |

## Verification
The hardest case to reach is a pending bit being set by a pin change in the same clock edge as a write-1-to-clear of that bit. The bus alone cannot order the two events. The bench therefore changes the external pin value at the same falling edge at which it presents the clear write, so both take effect on one rising edge. It then checks that the bit that changed stays set while the other cleared bits drop. The low-pending bits are also re-set on every cycle that the sample is 0, and the bench confirms that an all-ones clear leaves them set.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPIN = 32,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] ext_drive_en,
  input  logic [NPIN-1:0] ext_drive_val,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] irq_out,
  output logic [NPIN-1:0] conflict
);

  localparam logic [AW-1:0] O_SMP  = AW'('h00);
  localparam logic [AW-1:0] O_SEN  = AW'('h04);
  localparam logic [AW-1:0] O_OEN  = AW'('h08);
  localparam logic [AW-1:0] O_LVL  = AW'('h0C);
  localparam logic [AW-1:0] O_PUL  = AW'('h10);
  localparam logic [AW-1:0] O_DRV  = AW'('h14);
  localparam logic [AW-1:0] O_REN  = AW'('h18);
  localparam logic [AW-1:0] O_RPD  = AW'('h1C);
  localparam logic [AW-1:0] O_FEN  = AW'('h20);
  localparam logic [AW-1:0] O_FPD  = AW'('h24);
  localparam logic [AW-1:0] O_HEN  = AW'('h28);
  localparam logic [AW-1:0] O_HPD  = AW'('h2C);
  localparam logic [AW-1:0] O_LEN  = AW'('h30);
  localparam logic [AW-1:0] O_LPD  = AW'('h34);
  localparam logic [AW-1:0] O_AFE  = AW'('h38);
  localparam logic [AW-1:0] O_AFS  = AW'('h3C);
  localparam logic [AW-1:0] O_INV  = AW'('h40);

  logic [NPIN-1:0] sen_q, oen_q, lvl_q, pul_q, drv_q, inv_q, afe_q, afs_q;
  logic [NPIN-1:0] ren_q, fen_q, hen_q, len_q;
  logic [NPIN-1:0] rpd_q, fpd_q, hpd_q, lpd_q;
  logic [NPIN-1:0] smp_q, smp_d, own_lvl, wd;
  logic            wr_ok;

  assign wr_ok = bus_we && (bus_addr[1:0] == 2'b00);
  assign wd    = bus_wdata[NPIN-1:0];

  function automatic logic [NPIN-1:0] clr_mask(input logic hit, input logic [NPIN-1:0] d);
    clr_mask = hit ? d : '0;
  endfunction

  // Pin resolution: outside drive, then own output, then pull
  assign own_lvl = oen_q & (lvl_q ^ inv_q);
  assign pin_out = (ext_drive_en & ext_drive_val)
                 | (~ext_drive_en & oen_q & own_lvl)
                 | (~ext_drive_en & ~oen_q & pul_q);
  assign smp_d    = sen_q & pin_out;
  assign conflict = ext_drive_en & oen_q;
  assign irq_out  = (rpd_q & ren_q) | (fpd_q & fen_q) | (hpd_q & hen_q) | (lpd_q & len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sen_q <= '0; oen_q <= '0; lvl_q <= '0; pul_q <= '0;
      drv_q <= '0; inv_q <= '0; afe_q <= '0; afs_q <= '0;
      ren_q <= '0; fen_q <= '0; hen_q <= '0; len_q <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        O_SEN: sen_q <= wd;
        O_OEN: oen_q <= wd;
        O_LVL: lvl_q <= wd;
        O_PUL: pul_q <= wd;
        O_DRV: drv_q <= wd;
        O_REN: ren_q <= wd;
        O_FEN: fen_q <= wd;
        O_HEN: hen_q <= wd;
        O_LEN: len_q <= wd;
        O_AFE: afe_q <= wd;
        O_AFS: afs_q <= wd;
        O_INV: inv_q <= wd;
        default: ;
      endcase
    end
  end

  // Sample and sticky pending; a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= '0; rpd_q <= '0; fpd_q <= '0; hpd_q <= '0; lpd_q <= '0;
    end else begin
      smp_q <= smp_d;
      rpd_q <= (rpd_q & ~clr_mask(wr_ok && bus_addr == O_RPD, wd)) | (smp_d & ~smp_q);
      fpd_q <= (fpd_q & ~clr_mask(wr_ok && bus_addr == O_FPD, wd)) | (~smp_d & smp_q);
      hpd_q <= (hpd_q & ~clr_mask(wr_ok && bus_addr == O_HPD, wd)) | smp_d;
      lpd_q <= (lpd_q & ~clr_mask(wr_ok && bus_addr == O_LPD, wd)) | ~smp_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      case (bus_addr)
        O_SMP: bus_rdata = DW'(smp_q);
        O_SEN: bus_rdata = DW'(sen_q);
        O_OEN: bus_rdata = DW'(oen_q);
        O_LVL: bus_rdata = DW'(lvl_q);
        O_PUL: bus_rdata = DW'(pul_q);
        O_DRV: bus_rdata = DW'(drv_q);
        O_REN: bus_rdata = DW'(ren_q);
        O_RPD: bus_rdata = DW'(rpd_q);
        O_FEN: bus_rdata = DW'(fen_q);
        O_FPD: bus_rdata = DW'(fpd_q);
        O_HEN: bus_rdata = DW'(hen_q);
        O_HPD: bus_rdata = DW'(hpd_q);
        O_LEN: bus_rdata = DW'(len_q);
        O_LPD: bus_rdata = DW'(lpd_q);
        O_AFE: bus_rdata = DW'(afe_q);
        O_AFS: bus_rdata = DW'(afs_q);
        O_INV: bus_rdata = DW'(inv_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R6: a stored 1 sample always leaves high pending set
  a_r6_high_tracks_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (hpd_q & smp_q) == smp_q);

  // R6: after one clock, every 0 sample has its low pending bit set
  a_r6_low_tracks_sample: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lpd_q | smp_q) == '1));

  // R7: a 0->1 change of the stored sample leaves rise pending set
  a_r7_rise_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rpd_q & smp_q & ~$past(smp_q)) == (smp_q & ~$past(smp_q))));

  // R8: a clear write removes the bits unless a new rise arrives at that edge
  a_r8_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == O_RPD) |=>
      ((rpd_q & $past(wd) & ~(smp_q & ~$past(smp_q))) == '0));

  // R9: no interrupt line without some enable
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ((ren_q | fen_q | hen_q | len_q) != '0));

  // R11: conflicting pins carry the external value
  a_r11_ext_wins_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ ext_drive_val) & conflict) == '0);

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ext_drive_en = '0, ext_drive_val = '0;
  logic [31:0] pin_out, irq_out, conflict;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl dut_i (.*);

  // columns: ext_en, ext_val, oen, lvl, inv, pull, sen, expected pin
  localparam logic [31:0] VEC [5][8] = '{
    '{32'h0, 32'h0, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF00FF, 32'h0, 32'hFFFFFFFF, 32'h00FFFF00},
    '{32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hF0F0F0F0, 32'hFFFFFFFF, 32'hF0F0F0F0},
    '{32'hFFFFFFFF, 32'h12345678, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678},
    '{32'hFFFF0000, 32'hA5A50000, 32'h0000FF00, 32'h00003C00, 32'h00000F00, 32'h000000FF, 32'hFFFF00FF, 32'hA5A533FF},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    for (int a = 0; a <= 'h40; a += 4) rd("R1 reset register", 8'(a), 32'h0);
    check("R1 reset pin_out", pin_out, 32'h0);
    check("R1 reset irq_out", irq_out, 32'h0);
    check("R1 reset conflict", conflict, 32'h0);
    rst_n = 1;
    tick(); tick();
    rd("R6 low pending after reset", 8'h34, 32'hFFFFFFFF);

    foreach (VEC[i]) begin
      ext_drive_en = VEC[i][0]; ext_drive_val = VEC[i][1];
      wr(8'h08, VEC[i][2]); wr(8'h0C, VEC[i][3]); wr(8'h40, VEC[i][4]);
      wr(8'h10, VEC[i][5]); wr(8'h04, VEC[i][6]);
      check($sformatf("R3 R4 pin row %0d", i), pin_out, VEC[i][7]);
      tick();
      rd($sformatf("R5 sample row %0d", i), 8'h00, VEC[i][6] & VEC[i][7]);
    end
    rd("R2 output enable readback", 8'h08, 32'h0);
    rd("R2 sample enable readback", 8'h04, 32'hFFFFFFFF);

    ext_drive_en = '1; ext_drive_val = '0;
    tick(); tick();
    wr(8'h1C, '1); wr(8'h24, '1); wr(8'h2C, '1); wr(8'h34, '1);
    rd("R8 rise cleared", 8'h1C, 32'h0);
    rd("R8 fall cleared", 8'h24, 32'h0);
    rd("R8 high cleared", 8'h2C, 32'h0);
    rd("R8 low re-set wins", 8'h34, 32'hFFFFFFFF);
    ext_drive_val = 32'h3; tick();
    rd("R7 rise on 0 to 1", 8'h1C, 32'h3);
    rd("R6 high set", 8'h2C, 32'h3);
    ext_drive_val = 32'h1; tick();
    rd("R7 fall on 1 to 0", 8'h24, 32'h2);
    rd("R7 rise sticky", 8'h1C, 32'h3);
    wr(8'h1C, 32'h1);
    rd("R8 write 1 clears bit", 8'h1C, 32'h2);
    wr(8'h1C, 32'h0);
    rd("R8 write 0 no change", 8'h1C, 32'h2);
    rd("R6 high sticky after drop", 8'h2C, 32'h3);
    @(negedge clk);
    ext_drive_val = 32'h5; bus_we = 1; bus_addr = 8'h1C; bus_wdata = '1;
    @(negedge clk); bus_we = 0;
    rd("R8 set wins over clear", 8'h1C, 32'h4);

    wr(8'h1C, '1); wr(8'h24, '1); wr(8'h2C, '1); wr(8'h34, '1);
    rd("R6 high follows sample", 8'h2C, 32'h5);
    rd("R6 low follows sample", 8'h34, 32'hFFFFFFFA);
    wr(8'h18, 32'hFFFF);
    check("R9 enable without pending", irq_out, 32'h0);
    wr(8'h28, 32'h1);
    check("R9 high enable", irq_out, 32'h1);
    wr(8'h30, 32'h2);
    check("R9 high and low", irq_out, 32'h3);
    wr(8'h18, 32'h0); wr(8'h28, 32'h0); wr(8'h30, 32'h0);
    check("R9 all disabled", irq_out, 32'h0);
    wr(8'h20, 32'h4);
    ext_drive_val = 32'h1; tick();
    check("R9 fall interrupt", irq_out, 32'h4);
    rd("R7 fall pin2", 8'h24, 32'h4);

    ext_drive_en = 32'h3;
    wr(8'h08, 32'h0F);
    check("R11 conflict flags", conflict, 32'h3);
    check("R11 external wins", pin_out, 32'h1);
    wr(8'h14, '1); wr(8'h38, '1); wr(8'h3C, '1);
    check("R12 storage has no pin effect", pin_out, 32'h1);
    rd("R12 drive readback", 8'h14, 32'hFFFFFFFF);
    rd("R12 af enable readback", 8'h38, 32'hFFFFFFFF);
    rd("R12 af select readback", 8'h3C, 32'hFFFFFFFF);

    wr(8'h80, '1);
    rd("R10 undefined read", 8'h80, 32'h0);
    rd("R10 read past map", 8'h44, 32'h0);
    wr(8'h09, 32'h0);
    rd("R10 unaligned write ignored", 8'h08, 32'h0F);
    rd("R10 unaligned read", 8'h09, 32'h0);
    wr(8'h00, 32'h0);
    tick();
    rd("R2 sample register read-only", 8'h00, 32'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule